// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures the frequency of an oscillator under test by timing it against a known, free-running reference clock. A controller sets a window length, counted in cycles of the oscillator under test, and then sets the enable bit. The oscillator-clock side counts its own edges until it reaches that length. Meanwhile the reference-clock side counts reference edges, but only while the reference gate bit is set.

When the window closes, a done event crosses into the reference domain through a two-flop synchronizer. The reference count is then latched into the result register and the valid flag is raised. The result grows as the oscillator period grows, so the oscillator frequency is roughly `length * f_ref / result`. All register access is synchronous to the reference clock. Reads are combinational from the address.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset the control, status and result registers all read zero.
- R2: The control register is at address 0. The window length is in bits 23:0 and the meter enable is bit 24. Both read back as written, and all other bits read zero.
- R3: The status register is at address 1. Bit 8 is the reference gate and is writable. Bit 0 is the valid flag; it is read-only, and a write to it has no effect. The result register is at address 2, read-only, with the count in its low bits.
- R4: A write that changes the enable from 0 to 1 starts a new measurement. It clears the result and the valid flag at that clock edge, so both read zero on the next cycle.
- R5: The window closes after the programmed number of oscillator cycles, and the valid flag is then set. With length L and periods Tosc and Tref, the result lies between L*Tosc/Tref (rounded down) and (L+4)*Tosc/Tref + 4.
- R6: While the gate bit is clear, the reference counter does not advance. A completed window with the gate clear gives valid = 1 and a result of 0.
- R7: If the oscillator under test does not toggle, the window never closes: the valid flag stays 0 and the result stays 0.
- R8: Clearing the enable before the window closes abandons the measurement: the valid flag stays 0 and the result stays 0.
- R9: Once valid is set, the result and the valid flag hold their values until the next start, including after the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; also clocks the register interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_osc | input | 1 | Clock from the oscillator under test |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The assertions assume the window length changes only together with a 0-to-1 enable write, or while the meter is idle. They also assume the enable stays low long enough for the oscillator domain to observe it, about three oscillator periods plus three reference periods, before the next start. Without that, a stale done level could mask the next window. The bench writes the length and the enable in the same control write, and clears the enable with the length unchanged. It waits at least a microsecond after every clear, which is longer than the slowest oscillator period used in the bench.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES  = 2'd2;

  localparam int CTRL_EN_BIT    = 24;
  localparam int STAT_GATE_BIT  = 8;
  localparam int STAT_VALID_BIT = 0;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
`timescale 1ns/1ps
module fm_regs
  import fm_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              valid,
  input  logic [CNT_W-1:0]  result,
  output logic [LEN_W-1:0]  win_len,
  output logic              meter_en,
  output logic              gate_en,
  output logic              start_p,
  output logic [DATA_W-1:0] rdata
);
  logic [LEN_W-1:0] len_q, len_n;
  logic             en_q, en_n;
  logic             gate_q, gate_n;
  logic             ctrl_wr, stat_wr;
  logic             unused_wdata;

  assign ctrl_wr = we && (addr == ADDR_CTRL);
  assign stat_wr = we && (addr == ADDR_STAT);
  assign start_p = ctrl_wr && wdata[CTRL_EN_BIT] && !en_q;
  assign unused_wdata = ^wdata;

  always_comb begin
    len_n  = len_q;
    en_n   = en_q;
    gate_n = gate_q;
    if (ctrl_wr) begin
      len_n = wdata[LEN_W-1:0];
      en_n  = wdata[CTRL_EN_BIT];
    end
    if (stat_wr) gate_n = wdata[STAT_GATE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      en_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      len_q  <= len_n;
      en_q   <= en_n;
      gate_q <= gate_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[LEN_W-1:0]   = len_q;
        rdata[CTRL_EN_BIT] = en_q;
      end
      ADDR_STAT: begin
        rdata[STAT_GATE_BIT]  = gate_q;
        rdata[STAT_VALID_BIT] = valid;
      end
      ADDR_RES:  rdata[CNT_W-1:0] = result;
      default:   rdata = '0;
    endcase
  end

  assign win_len  = len_q;
  assign meter_en = en_q;
  assign gate_en  = gate_q;
endmodule

// File: rtl/fm_osc_window.sv
`timescale 1ns/1ps
module fm_osc_window #(
  parameter int LEN_W = 24
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic [LEN_W-1:0] win_len,
  output logic             done,
  output logic [LEN_W-1:0] cnt
);
  logic             en_d_q;
  logic             done_q, done_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             start;

  assign start = en_s && !en_d_q;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (!en_s || start) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == win_len) done_n = 1'b1;
      else                  cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      en_d_q <= en_s;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/fm_ref_meas.sv
`timescale 1ns/1ps
module fm_ref_meas #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             meter_en,
  input  logic             gate_en,
  input  logic             done_s,
  output logic             valid,
  output logic [CNT_W-1:0] result,
  output logic [CNT_W-1:0] ref_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             done_d_q;
  logic             run_q, run_n;
  logic             valid_q, valid_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] res_q, res_n;
  logic             done_rise;

  assign done_rise = done_s && !done_d_q;

  always_comb begin
    run_n   = run_q;
    valid_n = valid_q;
    cnt_n   = cnt_q;
    res_n   = res_q;
    if (start_p) begin
      run_n   = 1'b1;
      valid_n = 1'b0;
      cnt_n   = '0;
      res_n   = '0;
    end else if (run_q) begin
      if (gate_en && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      if (done_rise) begin
        res_n   = cnt_q;
        valid_n = 1'b1;
        run_n   = 1'b0;
      end else if (!meter_en) begin
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_d_q <= 1'b0;
      run_q    <= 1'b0;
      valid_q  <= 1'b0;
      cnt_q    <= '0;
      res_q    <= '0;
    end else begin
      done_d_q <= done_s;
      run_q    <= run_n;
      valid_q  <= valid_n;
      cnt_q    <= cnt_n;
      res_q    <= res_n;
    end
  end

  assign valid   = valid_q;
  assign result  = res_q;
  assign ref_cnt = cnt_q;
endmodule

// File: rtl/osc_freq_meter.sv
`timescale 1ns/1ps
module osc_freq_meter
  import fm_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              clk_osc,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [LEN_W-1:0] win_len;
  logic             meter_en;
  logic             gate_en;
  logic             start_p;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_result;
  logic [CNT_W-1:0] ref_cnt;
  logic             osc_rst_n;
  logic             en_osc;
  logic             done_osc;
  logic             done_ref;
  logic [LEN_W-1:0] osc_cnt;

  fm_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk_ref), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .valid(meas_valid), .result(meas_result),
    .win_len(win_len), .meter_en(meter_en), .gate_en(gate_en),
    .start_p(start_p), .rdata(reg_rdata)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_osc_rst_sync (
    .clk(clk_osc), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(clk_osc), .rst_n(osc_rst_n), .d(meter_en), .q(en_osc)
  );

  fm_osc_window #(.LEN_W(LEN_W)) u_window (
    .clk_osc(clk_osc), .rst_n(osc_rst_n), .en_s(en_osc),
    .win_len(win_len), .done(done_osc), .cnt(osc_cnt)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(done_osc), .q(done_ref)
  );

  fm_ref_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk_ref), .rst_n(rst_n), .start_p(start_p), .meter_en(meter_en),
    .gate_en(gate_en), .done_s(done_ref), .valid(meas_valid),
    .result(meas_result), .ref_cnt(ref_cnt)
  );
endmodule

// File: rtl/osc_freq_meter_chk.sv
`timescale 1ns/1ps
module osc_freq_meter_chk #(
  parameter int LEN_W = 24,
  parameter int CNT_W = 24
) (
  input logic             clk_ref,
  input logic             clk_osc,
  input logic             rst_n,
  input logic             osc_rst_n,
  input logic             start_p,
  input logic             gate_en,
  input logic             meas_valid,
  input logic [CNT_W-1:0] meas_result,
  input logic [CNT_W-1:0] ref_cnt,
  input logic             done_ref,
  input logic             en_osc,
  input logic [LEN_W-1:0] osc_cnt,
  input logic [LEN_W-1:0] win_len
);
  AST_START_CLEARS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start_p |=> (!meas_valid && meas_result == '0)); // R4

  AST_VALID_NEEDS_DONE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(meas_valid) |-> done_ref); // R5

  AST_OSC_CNT_BOUND: assert property (@(posedge clk_osc) disable iff (!osc_rst_n)
    en_osc |-> (osc_cnt <= win_len)); // R5

  AST_GATE_FREEZES: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!gate_en && !start_p) |=> $stable(ref_cnt)); // R6

  AST_VALID_HOLDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_valid && !start_p) |=> meas_valid); // R9

  AST_RESULT_HOLDS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_valid && !start_p) |=> $stable(meas_result)); // R9
endmodule

bind osc_freq_meter osc_freq_meter_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref), .clk_osc(clk_osc), .rst_n(rst_n), .osc_rst_n(osc_rst_n),
  .start_p(start_p), .gate_en(gate_en), .meas_valid(meas_valid),
  .meas_result(meas_result), .ref_cnt(ref_cnt), .done_ref(done_ref),
  .en_osc(en_osc), .osc_cnt(osc_cnt), .win_len(win_len)
);

// File: tb/test_osc_freq_meter.sv
`timescale 1ns/1ps
module test_osc_freq_meter;
  localparam int NVEC = 6;
  localparam int unsigned VEC_LEN  [0:NVEC-1] = '{16, 64, 100, 256, 1024, 300};
  localparam int unsigned VEC_HALF [0:NVEC-1] = '{50, 7, 13, 5, 9, 3};

  logic        clk_ref = 1'b0;
  logic        clk_osc = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int osc_half = 5;
  bit osc_run  = 1'b1;
  int n_tests  = 0;
  int n_fail   = 0;

  osc_freq_meter i_osc_freq_meter (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_osc(clk_osc), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk_ref = ~clk_ref;

  initial begin
    forever begin
      #(osc_half);
      if (osc_run) clk_osc = ~clk_osc;
    end
  end

  initial begin
    #(150000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: actual hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d, expected %s", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_ref);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_ref);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_ref);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_valid(input int limit, output bit seen);
    logic [31:0] s;
    seen = 1'b0;
    for (int k = 0; k < limit; k++) begin
      reg_read(2'd1, s);
      if (s[0]) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] kept;
    bit seen;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(posedge clk_ref);
    @(negedge clk_ref) rst_n = 1'b1;
    repeat (5) @(posedge clk_ref);

    // R1 reset state
    reg_read(2'd0, rd); check(rd == 0, "R1 ctrl", rd, "0");
    reg_read(2'd1, rd); check(rd == 0, "R1 status", rd, "0");
    reg_read(2'd2, rd); check(rd == 0, "R1 result", rd, "0");

    // R3 gate writable, valid bit ignores writes
    reg_write(2'd1, 32'h101);
    reg_read(2'd1, rd); check(rd == 32'h100, "R3 status write", rd, "256");

    // table of windows and oscillator periods
    for (int i = 0; i < NVEC; i++) begin
      int unsigned lo, hi, per;
      osc_half = VEC_HALF[i];
      per = 2 * VEC_HALF[i];
      lo = VEC_LEN[i] * per / 10;
      hi = (VEC_LEN[i] + 4) * per / 10 + 4;
      repeat (20) @(posedge clk_ref);
      reg_write(2'd0, (32'd1 << 24) | VEC_LEN[i]);
      reg_read(2'd0, rd);
      check(rd == ((32'd1 << 24) | VEC_LEN[i]), "R2 ctrl readback", rd,
            $sformatf("%0d", (32'd1 << 24) | VEC_LEN[i]));
      wait_valid(20000, seen);
      check(seen, "R5 valid set", seen, "1");
      reg_read(2'd2, rd);
      check(rd >= lo && rd <= hi, "R5 result range", rd, $sformatf("%0d..%0d", lo, hi));
      kept = rd;
      reg_write(2'd0, VEC_LEN[i]);
      repeat (100) @(posedge clk_ref);
    end

    // R9 result and valid held after enable cleared
    reg_read(2'd1, rd); check(rd[0] == 1'b1, "R9 valid held", rd[0], "1");
    reg_read(2'd2, rd); check(rd == kept, "R9 result held", rd, $sformatf("%0d", kept));

    // R4 start clears previous result and valid
    osc_half = 5;
    repeat (20) @(posedge clk_ref);
    reg_write(2'd0, (32'd1 << 24) | 32'd64);
    reg_read(2'd2, rd); check(rd == 0, "R4 result cleared", rd, "0");
    reg_read(2'd1, rd); check(rd[0] == 1'b0, "R4 valid cleared", rd[0], "0");
    wait_valid(20000, seen);
    check(seen, "R4 new measurement completes", seen, "1");
    reg_write(2'd0, 32'd64);
    repeat (100) @(posedge clk_ref);

    // R6 gate clear: valid with zero count
    reg_write(2'd1, 32'h0);
    reg_write(2'd0, (32'd1 << 24) | 32'd32);
    wait_valid(20000, seen);
    check(seen, "R6 valid with gate off", seen, "1");
    reg_read(2'd2, rd); check(rd == 0, "R6 result with gate off", rd, "0");
    reg_write(2'd0, 32'd32);
    reg_write(2'd1, 32'h100);
    repeat (100) @(posedge clk_ref);

    // R7 stopped oscillator
    osc_run = 1'b0;
    reg_write(2'd0, (32'd1 << 24) | 32'd32);
    repeat (2000) @(posedge clk_ref);
    reg_read(2'd1, rd); check(rd[0] == 1'b0, "R7 valid stays low", rd[0], "0");
    reg_read(2'd2, rd); check(rd == 0, "R7 result zero", rd, "0");
    reg_write(2'd0, 32'd32);
    osc_run = 1'b1;
    repeat (100) @(posedge clk_ref);

    // R8 abandon a window early
    osc_half = 50;
    repeat (20) @(posedge clk_ref);
    reg_write(2'd0, (32'd1 << 24) | 32'd1000);
    repeat (200) @(posedge clk_ref);
    reg_write(2'd0, 32'd1000);
    repeat (300) @(posedge clk_ref);
    reg_read(2'd1, rd); check(rd[0] == 1'b0, "R8 valid after abort", rd[0], "0");
    reg_read(2'd2, rd); check(rd == 0, "R8 result after abort", rd, "0");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule